// File: doc/BRIEF.md
# Per-CPU Interrupt Presentation Controller

This block is the presentation stage for a single processor. It keeps one pending interrupt slot, the processor's current priority and a separate priority for an inter-processor interrupt (IPI). A source controller offers interrupts (source number plus priority). The block either latches the offer and raises its interrupt line, or hands the source straight back as a reject. A more favored offer displaces the one already pending, and the displaced source is rejected so that the source controller can deliver it again later.

The processor side reaches a single 32-bit register and four operations: accept, end-of-interrupt write, priority write and IPI-priority write. The register holds the processor priority in bits 31:24 and the pending source in bits 23:0. The register and the IPI priority can be read at any time without side effects, which serves as a poll. When the pending slot becomes free and lower priorities may be delivered again, the block pulses a resend request to the source controller. Only one operation is taken per cycle, and a ready signal stalls the others.

Top module: `icp_presenter`

## Requirements
- R1: After reset the register reads 0x00000000, the IPI priority reads 0xFF, the interrupt line is low and no strobe is active. A lower priority value is more favored, 0xFF is least favored, and a source field of 0 means nothing is pending.
- R2: An offer whose priority is greater than or equal to the processor priority is rejected. So is an offer whose priority is not more favored than the one pending. A rejected offer leaves the register unchanged, and in the next cycle rejectValid pulses with rejectSrc equal to the offered source.
- R3: An offer that is not rejected is latched into bits 23:0, and its priority becomes the pending priority. The interrupt line is high from the next cycle. Any source that was pending is rejected in that same next cycle.
- R4: An accept takes the register value seen in its cycle. In the next cycle bits 31:24 hold the former pending priority, bits 23:0 are 0, the pending priority is 0xFF and the line is low.
- R5: An EOI write loads bits 31:24 of its data into the processor priority. In the next cycle eoiOutValid pulses with eoiOutSrc equal to data bits 23:0. If nothing is pending, resendReq also pulses.
- R6: A processor-priority write with a value lower than the current one cancels a pending interrupt whose priority is greater than or equal to the new value. The cancel clears the source, lowers the line and rejects that source. A write with a value greater than or equal to the current one, with nothing pending, pulses resendReq.
- R7: An IPI-priority write always updates the IPI priority. If the new value is lower than the processor priority and no pending interrupt has a priority less than or equal to it, any pending source is rejected. The IPI source number (parameter, default 2) is then latched with the new value as its priority and the line goes high. Otherwise nothing else changes.
- R8: A resend, triggered by an EOI or by a priority write, first latches the IPI when the IPI priority is lower than the new processor priority. It then pulses resendReq.
- R9: Requests in the same cycle are served in the order EOI, accept, priority write, IPI write, offer. Only the first present one is taken, and every later one sees its ready low and has no effect.
- R10: The interrupt line is high exactly when bits 23:0 of the register are nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| offerValid | input | 1 | Source controller offers an interrupt |
| offerSrc | input | 24 | Offered source number |
| offerPrio | input | 8 | Offered priority |
| offerReady | output | 1 | Offer taken this cycle |
| acceptReq | input | 1 | CPU accept (read and acknowledge) |
| acceptReady | output | 1 | Accept taken this cycle |
| eoiReq | input | 1 | CPU end-of-interrupt write |
| eoiData | input | 32 | EOI word: priority 31:24, source 23:0 |
| eoiReady | output | 1 | EOI taken this cycle |
| cpprWr | input | 1 | CPU processor-priority write |
| cpprData | input | 8 | New processor priority |
| cpprReady | output | 1 | Priority write taken this cycle |
| ipiWr | input | 1 | CPU IPI-priority write |
| ipiData | input | 8 | New IPI priority |
| ipiReady | output | 1 | IPI write taken this cycle |
| regData | output | 32 | Register value (accept result and poll) |
| ipiPrio | output | 8 | Current IPI priority (poll) |
| irqOut | output | 1 | Interrupt line to the CPU |
| rejectValid | output | 1 | Reject pulse to the source controller |
| rejectSrc | output | 24 | Rejected source number |
| eoiOutValid | output | 1 | EOI pulse to the source controller |
| eoiOutSrc | output | 24 | Source number of the EOI |
| resendReq | output | 1 | Resend request pulse to the source controller |

## Verification
The collision that matters most is a CPU operation landing in the same cycle as an offer from the source controller, or as another CPU operation. Example: an EOI that frees the slot while an accept and an offer are also waiting. The bench raises all five requests in one cycle, then drops them one at a time. It checks that only the highest-ranked ready is high. It also checks, from the register, the IPI priority and the strobes of the next cycle, that the losers left no trace. The loser data values are chosen so that any leak would change the register visibly.

// File: rtl/icp_pkg.sv
package icp_pkg;
  parameter int SRC_W  = 24;
  parameter int PRIO_W = 8;
  localparam int REG_W = SRC_W + PRIO_W;
  localparam logic [PRIO_W-1:0] PRIO_NONE = '1;

  typedef struct packed {
    logic              setCppr;
    logic [PRIO_W-1:0] cpprNext;
    logic              setPend;
    logic [SRC_W-1:0]  srcNext;
    logic [PRIO_W-1:0] prioNext;
    logic              clrPend;
    logic              setMfrr;
    logic [PRIO_W-1:0] mfrrNext;
    logic              rej;
    logic [SRC_W-1:0]  rejSrc;
    logic              eoi;
    logic [SRC_W-1:0]  eoiSrc;
    logic              resend;
  } icpStrobes_t;
endpackage

// File: rtl/icp_ctrl.sv
module icp_ctrl
  import icp_pkg::*;
#(
  parameter logic [SRC_W-1:0] IPI_SRC = 2
) (
  input  logic              offerValid,
  input  logic [SRC_W-1:0]  offerSrc,
  input  logic [PRIO_W-1:0] offerPrio,
  input  logic              acceptReq,
  input  logic              eoiReq,
  input  logic [REG_W-1:0]  eoiData,
  input  logic              cpprWr,
  input  logic [PRIO_W-1:0] cpprData,
  input  logic              ipiWr,
  input  logic [PRIO_W-1:0] ipiData,
  input  logic [PRIO_W-1:0] cppr,
  input  logic [SRC_W-1:0]  xisr,
  input  logic [PRIO_W-1:0] pendPrio,
  input  logic [PRIO_W-1:0] mfrr,
  output logic              offerReady,
  output logic              acceptReady,
  output logic              eoiReady,
  output logic              cpprReady,
  output logic              ipiReady,
  output icpStrobes_t       st
);
  logic hasPend;
  logic [PRIO_W-1:0] eoiPrio;

  assign hasPend     = (xisr != '0);
  assign eoiPrio     = eoiData[REG_W-1:SRC_W];
  assign eoiReady    = 1'b1;
  assign acceptReady = !eoiReq;
  assign cpprReady   = !(eoiReq || acceptReq);
  assign ipiReady    = !(eoiReq || acceptReq || cpprWr);
  assign offerReady  = !(eoiReq || acceptReq || cpprWr || ipiWr);

  always_comb begin
    st = '0;
    if (eoiReq) begin
      st.setCppr  = 1'b1;
      st.cpprNext = eoiPrio;
      st.eoi      = 1'b1;
      st.eoiSrc   = eoiData[SRC_W-1:0];
      if (!hasPend) begin
        st.resend = 1'b1;
        if (mfrr < eoiPrio) begin
          st.setPend  = 1'b1;
          st.srcNext  = IPI_SRC;
          st.prioNext = mfrr;
        end
      end
    end else if (acceptReq) begin
      st.setCppr  = 1'b1;
      st.cpprNext = pendPrio;
      st.clrPend  = 1'b1;
    end else if (cpprWr) begin
      st.setCppr  = 1'b1;
      st.cpprNext = cpprData;
      if (cpprData < cppr) begin
        if (hasPend && (cpprData <= pendPrio)) begin
          st.clrPend = 1'b1;
          st.rej     = 1'b1;
          st.rejSrc  = xisr;
        end
      end else if (!hasPend) begin
        st.resend = 1'b1;
        if (mfrr < cpprData) begin
          st.setPend  = 1'b1;
          st.srcNext  = IPI_SRC;
          st.prioNext = mfrr;
        end
      end
    end else if (ipiWr) begin
      st.setMfrr  = 1'b1;
      st.mfrrNext = ipiData;
      if ((ipiData < cppr) && !(hasPend && (pendPrio <= ipiData))) begin
        st.rej      = hasPend;
        st.rejSrc   = xisr;
        st.setPend  = 1'b1;
        st.srcNext  = IPI_SRC;
        st.prioNext = ipiData;
      end
    end else if (offerValid) begin
      if ((offerPrio >= cppr) || (hasPend && (pendPrio <= offerPrio))) begin
        st.rej    = 1'b1;
        st.rejSrc = offerSrc;
      end else begin
        st.rej      = hasPend;
        st.rejSrc   = xisr;
        st.setPend  = 1'b1;
        st.srcNext  = offerSrc;
        st.prioNext = offerPrio;
      end
    end
  end
endmodule

// File: rtl/icp_dpath.sv
module icp_dpath
  import icp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  icpStrobes_t       st,
  output logic [PRIO_W-1:0] cppr,
  output logic [SRC_W-1:0]  xisr,
  output logic [PRIO_W-1:0] pendPrio,
  output logic [PRIO_W-1:0] mfrr,
  output logic              irqOut,
  output logic              rejectValid,
  output logic [SRC_W-1:0]  rejectSrc,
  output logic              eoiOutValid,
  output logic [SRC_W-1:0]  eoiOutSrc,
  output logic              resendReq
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cppr        <= '0;
      xisr        <= '0;
      pendPrio    <= PRIO_NONE;
      mfrr        <= PRIO_NONE;
      irqOut      <= 1'b0;
      rejectValid <= 1'b0;
      rejectSrc   <= '0;
      eoiOutValid <= 1'b0;
      eoiOutSrc   <= '0;
      resendReq   <= 1'b0;
    end else begin
      if (st.setCppr) cppr <= st.cpprNext;
      if (st.setMfrr) mfrr <= st.mfrrNext;
      if (st.clrPend) begin
        xisr     <= '0;
        pendPrio <= PRIO_NONE;
        irqOut   <= 1'b0;
      end
      if (st.setPend) begin
        xisr     <= st.srcNext;
        pendPrio <= st.prioNext;
        irqOut   <= 1'b1;
      end
      rejectValid <= st.rej;
      rejectSrc   <= st.rejSrc;
      eoiOutValid <= st.eoi;
      eoiOutSrc   <= st.eoiSrc;
      resendReq   <= st.resend;
    end
  end
endmodule

// File: rtl/icp_presenter.sv
module icp_presenter
  import icp_pkg::*;
#(
  parameter logic [SRC_W-1:0] IPI_SRC = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              offerValid,
  input  logic [SRC_W-1:0]  offerSrc,
  input  logic [PRIO_W-1:0] offerPrio,
  output logic              offerReady,
  input  logic              acceptReq,
  output logic              acceptReady,
  input  logic              eoiReq,
  input  logic [REG_W-1:0]  eoiData,
  output logic              eoiReady,
  input  logic              cpprWr,
  input  logic [PRIO_W-1:0] cpprData,
  output logic              cpprReady,
  input  logic              ipiWr,
  input  logic [PRIO_W-1:0] ipiData,
  output logic              ipiReady,
  output logic [REG_W-1:0]  regData,
  output logic [PRIO_W-1:0] ipiPrio,
  output logic              irqOut,
  output logic              rejectValid,
  output logic [SRC_W-1:0]  rejectSrc,
  output logic              eoiOutValid,
  output logic [SRC_W-1:0]  eoiOutSrc,
  output logic              resendReq
);
  icpStrobes_t       st;
  logic [PRIO_W-1:0] cppr;
  logic [SRC_W-1:0]  xisr;
  logic [PRIO_W-1:0] pendPrio;

  icp_ctrl #(.IPI_SRC(IPI_SRC)) ctrl_i (
    .offerValid(offerValid), .offerSrc(offerSrc), .offerPrio(offerPrio),
    .acceptReq(acceptReq), .eoiReq(eoiReq), .eoiData(eoiData),
    .cpprWr(cpprWr), .cpprData(cpprData), .ipiWr(ipiWr), .ipiData(ipiData),
    .cppr(cppr), .xisr(xisr), .pendPrio(pendPrio), .mfrr(ipiPrio),
    .offerReady(offerReady), .acceptReady(acceptReady), .eoiReady(eoiReady),
    .cpprReady(cpprReady), .ipiReady(ipiReady), .st(st)
  );

  icp_dpath dpath_i (
    .clk(clk), .rstN(rstN), .st(st),
    .cppr(cppr), .xisr(xisr), .pendPrio(pendPrio), .mfrr(ipiPrio),
    .irqOut(irqOut), .rejectValid(rejectValid), .rejectSrc(rejectSrc),
    .eoiOutValid(eoiOutValid), .eoiOutSrc(eoiOutSrc), .resendReq(resendReq)
  );

  assign regData = {cppr, xisr};
endmodule

// File: rtl/icp_presenter_chk.sv
module icp_presenter_chk
  import icp_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              offerValid,
  input logic [SRC_W-1:0]  offerSrc,
  input logic [PRIO_W-1:0] offerPrio,
  input logic              offerReady,
  input logic              acceptReq,
  input logic              acceptReady,
  input logic              eoiReq,
  input logic [REG_W-1:0]  eoiData,
  input logic              cpprReady,
  input logic              ipiWr,
  input logic [PRIO_W-1:0] ipiData,
  input logic              ipiReady,
  input logic [REG_W-1:0]  regData,
  input logic [PRIO_W-1:0] ipiPrio,
  input logic              irqOut,
  input logic              rejectValid,
  input logic [SRC_W-1:0]  rejectSrc,
  input logic              eoiOutValid,
  input logic [SRC_W-1:0]  eoiOutSrc
);
  // R10
  irq_tracks_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == (regData[SRC_W-1:0] != '0));

  // R4
  accept_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (acceptReq && acceptReady) |=> (!irqOut && regData[SRC_W-1:0] == '0));

  // R2
  offer_low_reject_chk: assert property (@(posedge clk) disable iff (!rstN)
    (offerValid && offerReady && offerPrio >= regData[REG_W-1:SRC_W])
    |=> (rejectValid && rejectSrc == $past(offerSrc) && $stable(regData)));

  // R5
  eoi_forward_chk: assert property (@(posedge clk) disable iff (!rstN)
    eoiReq |=> (eoiOutValid && eoiOutSrc == $past(eoiData[SRC_W-1:0])
               && regData[REG_W-1:SRC_W] == $past(eoiData[REG_W-1:SRC_W])));

  // R9
  eoi_blocks_rest_chk: assert property (@(posedge clk) disable iff (!rstN)
    eoiReq |-> (!acceptReady && !cpprReady && !ipiReady && !offerReady));

  // R7
  ipi_prio_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ipiWr && ipiReady) |=> (ipiPrio == $past(ipiData)));
endmodule

bind icp_presenter icp_presenter_chk chk_i (.*);

// File: tb/icp_presenter_tb_top.sv
module icp_presenter_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic offerValid = 0, acceptReq = 0, eoiReq = 0, cpprWr = 0, ipiWr = 0;
  logic [23:0] offerSrc = '0;
  logic [7:0]  offerPrio = '0, cpprData = '0, ipiData = '0;
  logic [31:0] eoiData = '0;
  logic offerReady, acceptReady, eoiReady, cpprReady, ipiReady;
  logic [31:0] regData;
  logic [7:0]  ipiPrio;
  logic irqOut, rejectValid, eoiOutValid, resendReq;
  logic [23:0] rejectSrc, eoiOutSrc;

  int checks = 0;
  int errors = 0;

  typedef struct {
    string       tag;
    logic [31:0] regv;
    logic [7:0]  ipi;
    logic        irq;
    logic        rv;
    logic [23:0] rs;
    logic        ev;
    logic [23:0] es;
    logic        rsd;
  } exp_t;

  exp_t expQ[$];

  icp_presenter dut_i (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // monitor: pops one expected item after each edge that follows a driven op
  always @(posedge clk) begin
    #1;
    if (expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      check(e.tag,
            {regData, ipiPrio, irqOut, rejectValid, rejectSrc},
            {e.regv, e.ipi, e.irq, e.rv, e.rs});
      check({e.tag, " strobes"},
            {39'd0, eoiOutValid, eoiOutSrc, resendReq},
            {39'd0, e.ev, e.es, e.rsd});
    end
  end

  task automatic drive(input logic e, a, c, i, o,
                       input logic [31:0] ed, input logic [7:0] cd, id,
                       input logic [23:0] os, input logic [7:0] op);
    @(negedge clk);
    eoiReq = e; acceptReq = a; cpprWr = c; ipiWr = i; offerValid = o;
    eoiData = ed; cpprData = cd; ipiData = id; offerSrc = os; offerPrio = op;
  endtask

  task automatic release_ops();
    @(posedge clk);
    #2;
    eoiReq = 0; acceptReq = 0; cpprWr = 0; ipiWr = 0; offerValid = 0;
  endtask

  task automatic expect_item(input string tag, input logic [31:0] r, input logic [7:0] ip,
                             input logic irq, rv, input logic [23:0] rs,
                             input logic ev, input logic [23:0] es, input logic rsd);
    exp_t x;
    x.tag = tag; x.regv = r; x.ipi = ip; x.irq = irq; x.rv = rv; x.rs = rs;
    x.ev = ev; x.es = es; x.rsd = rsd;
    expQ.push_back(x);
  endtask

  task automatic offer(input string tag, input logic [23:0] s, input logic [7:0] p,
                       input logic [31:0] r, input logic [7:0] ip, input logic irq,
                       input logic rv, input logic [23:0] rs);
    drive(0, 0, 0, 0, 1, 0, 0, 0, s, p);
    expect_item(tag, r, ip, irq, rv, rs, 0, 0, 0);
    release_ops();
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    check("R1 reset", {regData, ipiPrio, irqOut, rejectValid, eoiOutValid, resendReq},
          {32'h0, 8'hFF, 4'b0000});

    // R2 offer against priority 0 is rejected
    offer("R2 reject vs cppr0", 24'h10, 8'h05, 32'h0, 8'hFF, 0, 1, 24'h10);

    // R6 less favored priority write with nothing pending -> resend
    drive(0, 0, 1, 0, 0, 0, 8'hFF, 0, 0, 0);
    expect_item("R6 resend on cppr raise", 32'hFF000000, 8'hFF, 0, 0, 0, 0, 0, 1);
    release_ops();

    // R3 offer taken
    offer("R3 take first", 24'h10, 8'h05, 32'hFF000010, 8'hFF, 1, 0, 0);
    // R2 equal to pending -> rejected
    offer("R2 reject equal pending", 24'h20, 8'h05, 32'hFF000010, 8'hFF, 1, 1, 24'h20);
    // R3 preempt: old rejected
    offer("R3 preempt", 24'h30, 8'h03, 32'hFF000030, 8'hFF, 1, 1, 24'h10);

    // R4 accept
    drive(0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    expect_item("R4 accept", 32'h03000000, 8'hFF, 0, 0, 0, 0, 0, 0);
    release_ops();

    // R2 equal to cppr -> rejected
    offer("R2 reject equal cppr", 24'h40, 8'h03, 32'h03000000, 8'hFF, 0, 1, 24'h40);

    // R5 EOI with nothing pending
    drive(1, 0, 0, 0, 0, 32'hFF000030, 0, 0, 0, 0);
    expect_item("R5 eoi", 32'hFF000000, 8'hFF, 0, 0, 0, 1, 24'h30, 1);
    release_ops();

    // R7 IPI write taken
    drive(0, 0, 0, 1, 0, 0, 0, 8'h04, 0, 0);
    expect_item("R7 ipi taken", 32'hFF000002, 8'h04, 1, 0, 0, 0, 0, 0);
    release_ops();

    offer("R2 reject vs ipi", 24'h50, 8'h04, 32'hFF000002, 8'h04, 1, 1, 24'h50);
    offer("R3 preempt ipi", 24'h50, 8'h01, 32'hFF000050, 8'h04, 1, 1, 24'h000002);

    // R7 IPI write blocked by more favored pending
    drive(0, 0, 0, 1, 0, 0, 0, 8'h06, 0, 0);
    expect_item("R7 ipi blocked", 32'hFF000050, 8'h06, 1, 0, 0, 0, 0, 0);
    release_ops();

    // R6 cancel pending
    drive(0, 0, 1, 0, 0, 0, 8'h01, 0, 0, 0);
    expect_item("R6 cancel", 32'h01000000, 8'h06, 0, 1, 24'h50, 0, 0, 0);
    release_ops();

    // R8 resend from priority write picks up IPI
    drive(0, 0, 1, 0, 0, 0, 8'h08, 0, 0, 0);
    expect_item("R8 resend ipi via cppr", 32'h08000002, 8'h06, 1, 0, 0, 0, 0, 1);
    release_ops();

    drive(0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    expect_item("R4 accept ipi", 32'h06000000, 8'h06, 0, 0, 0, 0, 0, 0);
    release_ops();

    // R8 resend from EOI picks up IPI
    drive(1, 0, 0, 0, 0, 32'h08000002, 0, 0, 0, 0);
    expect_item("R8 resend ipi via eoi", 32'h08000002, 8'h06, 1, 0, 0, 1, 24'h2, 1);
    release_ops();

    // R9 all five at once: EOI wins
    drive(1, 1, 1, 1, 1, 32'hFF000002, 8'h00, 8'h00, 24'h77, 8'h00);
    #1;
    check("R9 readies eoi wins", {eoiReady, acceptReady, cpprReady, ipiReady, offerReady},
          5'b10000);
    expect_item("R9 only eoi applied", 32'hFF000002, 8'h06, 1, 0, 0, 1, 24'h2, 0);
    @(posedge clk);
    #2;
    eoiReq = 0;
    // accept wins over the rest
    @(negedge clk);
    #1;
    check("R9 readies accept wins", {eoiReady, acceptReady, cpprReady, ipiReady, offerReady},
          5'b11000);
    expect_item("R9 only accept applied", 32'h06000000, 8'h06, 0, 0, 0, 0, 0, 0);
    @(posedge clk);
    #2;
    acceptReq = 0; cpprWr = 0;
    @(negedge clk);
    #1;
    check("R9 readies ipi over offer", {ipiReady, offerReady}, 2'b10);
    ipiWr = 0;
    #1;
    check("R9 offer ready alone", {63'd0, offerReady}, 64'd1);
    offerValid = 0;

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule